// File: doc/BRIEF.md
# Verlet Integrate Update Unit

This block keeps the per-atom state for one node of a parallel molecular dynamics engine. Position, velocity and force are each held in three axis banks (x, y, z). The engine integrates one time step in two halves. The first half runs after forces are known. The second half runs after the next force evaluation and the data exchange with other nodes have both finished.

A start command selects the half and gives the number of atoms. It also carries two step constants: `dtfm` scales force into a velocity change, and `dtv` scales velocity into a position change. In the opening half, every atom first gets its velocity raised by force times `dtfm`. Its position is then raised by that new velocity times `dtv`. In the closing half, only the velocity step is done. All values are Q16.16 two's-complement numbers.

The unit handles one axis element per clock through a short pipeline. It raises `done` for a single cycle once the last atom's z element has been written. When the unit is idle, a plain word-wide port lets the surrounding system load and inspect the banks.

Top module: `verlet_step_unit`

## Requirements
- R1: While reset is asserted and after it is released, `busy` and `done` are low. Asserting reset during a run aborts the run.
- R2: With `phase`=0 (opening half), each element first gets velocity v' = v + S(f, dtfm). Position then becomes p + S(v', dtv), so the position step uses the velocity just produced.
- R3: With `phase`=1 (closing half), each element gets velocity v' = v + S(f, dtfm). Position is not written.
- R4: S(a, b) is formed from the full 64-bit signed product a*b. 2^15 is added to it, and the result is shifted right arithmetically by 16, so ties round toward plus infinity. The result is then clamped to the range 0x80000000 .. 0x7FFFFFFF.
- R5: Each addition into velocity or position saturates: it gives 0x7FFFFFFF on positive overflow and 0x80000000 on negative overflow.
- R6: A run touches atoms 0 .. `atom_count`-1 (where 1 <= `atom_count` <= NATOM) on all three axes. Atoms at or above `atom_count` keep their values, and the force banks are never written by a run.
- R7: Count the edge that samples an accepted `start` as edge 0. Then `done` is high for exactly one cycle, following edge 3*`atom_count`+2, and `busy` is low in that cycle.
- R8: When idle, `mem_we` writes `mem_wdata` into the bank picked by `mem_sel` (0 position, 1 velocity, 2 force) and `mem_axis` (0 x, 1 y, 2 z), at index `mem_atom`. `mem_rdata` shows that word combinationally. A write attempted while `busy` is high has no effect.
- R9: `phase`, `atom_count`, `dtfm` and `dtv` are captured at the accepted start. A `start` raised while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run when idle |
| phase | input | 1 | 0 opening half, 1 closing half |
| atom_count | input | CW | Number of atoms to sweep |
| dtfm | input | 32 | Force-to-velocity step constant, Q16.16 |
| dtv | input | 32 | Velocity-to-position step constant, Q16.16 |
| mem_we | input | 1 | Bank write strobe (idle only) |
| mem_sel | input | 2 | Quantity select |
| mem_axis | input | 2 | Axis select |
| mem_atom | input | AW | Atom index |
| mem_wdata | input | 32 | Write data |
| mem_rdata | output | 32 | Read data at the selected address |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
Updated bank contents can be read through `mem_rdata` without delay, but the checks only read them after `done` has risen. The bench samples every signal on falling edges. It counts those falling edges from the one right after the start-sampling edge, which is number 1, and expects `done` at count 3*`atom_count`+3. This matches the two pipeline registers plus the write edge. The bench also checks that `done` is low on the very next falling edge. Requests made during a run, such as a host write or a second start, are sent a set number of edges after the run begins. Their absence of effect is then judged from the bank contents and the `done` timing once the original run ends.

// File: rtl/vvu_pkg.sv
package vvu_pkg;
  localparam int unsigned WORD = 32;
  localparam int unsigned FRAC = 16;

  typedef logic signed [WORD-1:0] fx_t;
  typedef logic signed [2*WORD-1:0] fx_wide_t;
  typedef enum logic {PH_INIT = 1'b0, PH_FINAL = 1'b1} phase_e;

  localparam logic [1:0] Q_POS = 2'd0;
  localparam logic [1:0] Q_VEL = 2'd1;
  localparam logic [1:0] Q_FRC = 2'd2;

  localparam fx_t FX_MAX = {1'b0, {(WORD-1){1'b1}}};
  localparam fx_t FX_MIN = {1'b1, {(WORD-1){1'b0}}};
  localparam fx_wide_t WIDE_MAX = (2*WORD)'(FX_MAX);
  localparam fx_wide_t WIDE_MIN = (2*WORD)'(FX_MIN);
  localparam fx_wide_t HALF_LSB = (2*WORD)'(1) << (FRAC-1);

  // clamp a wide signed value into the word range
  function automatic fx_t fx_clip(input fx_wide_t x);
    if (x > WIDE_MAX) return FX_MAX;
    else if (x < WIDE_MIN) return FX_MIN;
    else return x[WORD-1:0];
  endfunction

  // product of two Q16.16 values, rounded half up, clamped
  function automatic fx_t fx_scale(input fx_t a, input fx_t b);
    fx_wide_t prod;
    prod = (2*WORD)'(a) * (2*WORD)'(b);
    prod = prod + HALF_LSB;
    return fx_clip(prod >>> FRAC);
  endfunction

  function automatic fx_t fx_add(input fx_t a, input fx_t b);
    return fx_clip((2*WORD)'(a) + (2*WORD)'(b));
  endfunction
endpackage

// File: rtl/vvu_rst_sync.sv
module vvu_rst_sync (
  input  logic clk,
  input  logic rst_an,
  output logic rst_sn
);
  logic stage1_q, stage2_q;

  always_ff @(posedge clk or negedge rst_an) begin
    if (!rst_an) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sn = stage2_q;
endmodule

// File: rtl/vvu_bank.sv
module vvu_bank import vvu_pkg::*; #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  fx_t           wdata,
  input  logic [AW-1:0] raddr_a,
  output fx_t           rdata_a,
  input  logic [AW-1:0] raddr_b,
  output fx_t           rdata_b
);
  fx_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/vvu_sweep.sv
module vvu_sweep #(
  parameter int unsigned NATOM = 16,
  parameter int unsigned AW    = $clog2(NATOM),
  parameter int unsigned CW    = $clog2(NATOM+1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [CW-1:0] count,
  output logic          iss_valid,
  output logic [AW-1:0] iss_atom,
  output logic [1:0]    iss_axis,
  output logic          iss_last
);
  logic          act_q, act_d;
  logic [AW-1:0] atom_q, atom_d;
  logic [1:0]    axis_q, axis_d;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_m1;

  assign cnt_m1   = cnt_q - CW'(1);
  assign iss_last = act_q && (axis_q == 2'd2) && (CW'(atom_q) == cnt_m1);

  always_comb begin
    act_d  = act_q;
    atom_d = atom_q;
    axis_d = axis_q;
    if (!act_q) begin
      if (go) begin
        act_d  = 1'b1;
        atom_d = '0;
        axis_d = '0;
      end
    end else if (axis_q == 2'd2) begin
      axis_d = '0;
      atom_d = atom_q + AW'(1);
      if (iss_last) act_d = 1'b0;
    end else begin
      axis_d = axis_q + 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      atom_q <= '0;
      axis_q <= '0;
    end else begin
      act_q  <= act_d;
      atom_q <= atom_d;
      axis_q <= axis_d;
    end
  end

  always_ff @(posedge clk) begin
    if (go && !act_q) cnt_q <= count;
  end

  assign iss_valid = act_q;
  assign iss_atom  = atom_q;
  assign iss_axis  = axis_q;
endmodule

// File: rtl/vvu_pipe.sv
module vvu_pipe import vvu_pkg::*; #(
  parameter int unsigned AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  fx_t           dtfm,
  input  fx_t           dtv,
  input  logic          in_valid,
  input  logic [AW-1:0] in_atom,
  input  logic [1:0]    in_axis,
  input  logic          in_last,
  input  fx_t           in_f,
  input  fx_t           in_v,
  input  fx_t           in_p,
  output logic          out_valid,
  output logic [AW-1:0] out_atom,
  output logic [1:0]    out_axis,
  output logic          out_last,
  output fx_t           out_v,
  output fx_t           out_p
);
  // stage 1: operands as read from the banks
  logic          s1_vld, s1_last;
  logic [AW-1:0] s1_atom;
  logic [1:0]    s1_axis;
  fx_t           s1_f, s1_v, s1_p;
  // stage 2: velocity already advanced
  logic          s2_vld, s2_last;
  logic [AW-1:0] s2_atom;
  logic [1:0]    s2_axis;
  fx_t           s2_v, s2_p;
  fx_t           v_next;

  assign v_next = fx_add(s1_v, fx_scale(s1_f, dtfm));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld <= 1'b0;
      s2_vld <= 1'b0;
    end else begin
      s1_vld <= in_valid;
      s2_vld <= s1_vld;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      s1_atom <= in_atom;
      s1_axis <= in_axis;
      s1_last <= in_last;
      s1_f    <= in_f;
      s1_v    <= in_v;
      s1_p    <= in_p;
    end
    if (s1_vld) begin
      s2_atom <= s1_atom;
      s2_axis <= s1_axis;
      s2_last <= s1_last;
      s2_v    <= v_next;
      s2_p    <= s1_p;
    end
  end

  assign out_valid = s2_vld;
  assign out_atom  = s2_atom;
  assign out_axis  = s2_axis;
  assign out_last  = s2_last;
  assign out_v     = s2_v;
  assign out_p     = fx_add(s2_p, fx_scale(s2_v, dtv));
endmodule

// File: rtl/verlet_step_unit.sv
module verlet_step_unit import vvu_pkg::*; #(
  parameter int unsigned NATOM = 16,
  parameter int unsigned AW    = $clog2(NATOM),
  parameter int unsigned CW    = $clog2(NATOM+1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            phase,
  input  logic [CW-1:0]   atom_count,
  input  logic [WORD-1:0] dtfm,
  input  logic [WORD-1:0] dtv,
  input  logic            mem_we,
  input  logic [1:0]      mem_sel,
  input  logic [1:0]      mem_axis,
  input  logic [AW-1:0]   mem_atom,
  input  logic [WORD-1:0] mem_wdata,
  output logic [WORD-1:0] mem_rdata,
  output logic            busy,
  output logic            done
);
  localparam int unsigned NQTY = 3;
  localparam int unsigned NAXIS = 3;

  logic   rst_sn;
  logic   go;
  logic   busy_q, busy_d, done_q, done_d;
  phase_e phase_q;
  fx_t    dtfm_q, dtv_q;

  logic          iss_valid, iss_last;
  logic [AW-1:0] iss_atom;
  logic [1:0]    iss_axis;
  fx_t           op_f, op_v, op_p;

  logic          wr_valid, wr_last;
  logic [AW-1:0] wr_atom;
  logic [1:0]    wr_axis;
  fx_t           wr_v, wr_p;
  logic          pos_we, vel_we;

  fx_t pipe_rd [NQTY][NAXIS];
  fx_t host_rd [NQTY][NAXIS];

  vvu_rst_sync u_rst (.clk(clk), .rst_an(rst_n), .rst_sn(rst_sn));

  assign go = start && !busy_q;

  always_comb begin
    busy_d = busy_q;
    if (go) busy_d = 1'b1;
    else if (wr_valid && wr_last) busy_d = 1'b0;
    done_d = wr_valid && wr_last;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      phase_q <= PH_INIT;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      if (go) phase_q <= phase_e'(phase);
    end
  end

  always_ff @(posedge clk) begin
    if (go) begin
      dtfm_q <= dtfm;
      dtv_q  <= dtv;
    end
  end

  vvu_sweep #(.NATOM(NATOM), .AW(AW), .CW(CW)) u_sweep (
    .clk(clk), .rst_n(rst_sn), .go(go), .count(atom_count),
    .iss_valid(iss_valid), .iss_atom(iss_atom), .iss_axis(iss_axis), .iss_last(iss_last)
  );

  always_comb begin
    case (iss_axis)
      2'd1:    begin op_f = pipe_rd[Q_FRC][1]; op_v = pipe_rd[Q_VEL][1]; op_p = pipe_rd[Q_POS][1]; end
      2'd2:    begin op_f = pipe_rd[Q_FRC][2]; op_v = pipe_rd[Q_VEL][2]; op_p = pipe_rd[Q_POS][2]; end
      default: begin op_f = pipe_rd[Q_FRC][0]; op_v = pipe_rd[Q_VEL][0]; op_p = pipe_rd[Q_POS][0]; end
    endcase
  end

  vvu_pipe #(.AW(AW)) u_pipe (
    .clk(clk), .rst_n(rst_sn), .dtfm(dtfm_q), .dtv(dtv_q),
    .in_valid(iss_valid), .in_atom(iss_atom), .in_axis(iss_axis), .in_last(iss_last),
    .in_f(op_f), .in_v(op_v), .in_p(op_p),
    .out_valid(wr_valid), .out_atom(wr_atom), .out_axis(wr_axis), .out_last(wr_last),
    .out_v(wr_v), .out_p(wr_p)
  );

  assign vel_we = wr_valid;
  assign pos_we = wr_valid && (phase_q == PH_INIT);

  for (genvar q = 0; q < NQTY; q++) begin : g_qty
    for (genvar a = 0; a < NAXIS; a++) begin : g_axis
      logic          run_we, host_we, bank_we;
      logic [AW-1:0] bank_addr;
      fx_t           run_data, bank_data;

      if (q == Q_VEL) begin : g_vel
        assign run_we   = vel_we && (wr_axis == 2'(a));
        assign run_data = wr_v;
      end else if (q == Q_POS) begin : g_pos
        assign run_we   = pos_we && (wr_axis == 2'(a));
        assign run_data = wr_p;
      end else begin : g_frc
        assign run_we   = 1'b0;
        assign run_data = wr_v;
      end

      assign host_we   = mem_we && !busy_q && (mem_sel == 2'(q)) && (mem_axis == 2'(a));
      assign bank_we   = run_we || host_we;
      assign bank_addr = run_we ? wr_atom : mem_atom;
      assign bank_data = run_we ? run_data : fx_t'(mem_wdata);

      vvu_bank #(.DEPTH(NATOM), .AW(AW)) u_bank (
        .clk(clk), .we(bank_we), .waddr(bank_addr), .wdata(bank_data),
        .raddr_a(iss_atom), .rdata_a(pipe_rd[q][a]),
        .raddr_b(mem_atom), .rdata_b(host_rd[q][a])
      );
    end
  end

  always_comb begin
    mem_rdata = '0;
    for (int q = 0; q < NQTY; q++) begin
      for (int a = 0; a < NAXIS; a++) begin
        if (mem_sel == 2'(q) && mem_axis == 2'(a)) mem_rdata = host_rd[q][a];
      end
    end
  end

  assign busy = busy_q;
  assign done = done_q;
endmodule

// File: rtl/vvu_chk.sv
module vvu_chk (
  input logic clk,
  input logic rst_sn,
  input logic start,
  input logic busy,
  input logic done,
  input logic final_q,
  input logic pos_we,
  input logic vel_we
);
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_sn)
    done |=> !done);
  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_sn)
    done |-> !busy);
  p_final_keeps_pos_r3: assert property (@(posedge clk) disable iff (!rst_sn)
    final_q |-> !pos_we);
  p_init_pairs_r2: assert property (@(posedge clk) disable iff (!rst_sn)
    (!final_q && vel_we) |-> pos_we);
  p_write_in_run_r8: assert property (@(posedge clk) disable iff (!rst_sn)
    (pos_we || vel_we) |-> busy);
  p_run_needs_start_r9: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(busy) |-> $past(start));
endmodule

bind verlet_step_unit vvu_chk u_chk (
  .clk(clk), .rst_sn(rst_sn), .start(start), .busy(busy), .done(done),
  .final_q(phase_q), .pos_we(pos_we), .vel_we(vel_we)
);

// File: tb/sim_verlet_step_unit.sv
module sim_verlet_step_unit;
  localparam int NATOM = 16;
  localparam int AW = $clog2(NATOM);
  localparam int CW = $clog2(NATOM+1);

  typedef struct packed {
    logic        ph;
    logic [31:0] dtfm, dtv, f, v, p, ev, ep;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{1'b0, 32'h00008000, 32'h00010000, 32'h00020000, 32'h00010000, 32'h00030000, 32'h00020000, 32'h00050000},
    '{1'b1, 32'h00008000, 32'h00010000, 32'h00020000, 32'h00010000, 32'h00030000, 32'h00020000, 32'h00030000},
    '{1'b0, 32'h00010000, 32'h00008000, 32'hFFFF0000, 32'h00000000, 32'h00000000, 32'hFFFF0000, 32'hFFFF8000},
    '{1'b0, 32'h00000001, 32'h00000000, 32'h00008000, 32'h00000000, 32'h00001234, 32'h00000001, 32'h00001234},
    '{1'b0, 32'h00000001, 32'h00000000, 32'hFFFF8000, 32'h00000005, 32'h00000000, 32'h00000005, 32'h00000000},
    '{1'b0, 32'h7FFFFFFF, 32'h00010000, 32'h7FFFFFFF, 32'h00000000, 32'h00010000, 32'h7FFFFFFF, 32'h7FFFFFFF},
    '{1'b0, 32'h7FFFFFFF, 32'h00000000, 32'h80000000, 32'hFFFF0000, 32'h00000005, 32'h80000000, 32'h00000005},
    '{1'b1, 32'h00010000, 32'h00000000, 32'h40000000, 32'h40000000, 32'h00000000, 32'h7FFFFFFF, 32'h00000000}
  };

  logic          clk, rst_n, start, phase, mem_we, busy, done;
  logic [CW-1:0] atom_count;
  logic [31:0]   dtfm, dtv, mem_wdata, mem_rdata;
  logic [1:0]    mem_sel, mem_axis;
  logic [AW-1:0] mem_atom;

  int n_chk = 0;
  int n_err = 0;

  verlet_step_unit #(.NATOM(NATOM)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .phase(phase), .atom_count(atom_count),
    .dtfm(dtfm), .dtv(dtv), .mem_we(mem_we), .mem_sel(mem_sel), .mem_axis(mem_axis),
    .mem_atom(mem_atom), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .busy(busy), .done(done)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [31:0] m_sat(input longint x);
    if (x > 64'sd2147483647) return 32'h7FFFFFFF;
    if (x < -64'sd2147483648) return 32'h80000000;
    return x[31:0];
  endfunction

  function automatic logic [31:0] m_scale(input logic [31:0] a, input logic [31:0] b);
    longint pr;
    pr = longint'($signed(a)) * longint'($signed(b)) + 64'sd32768;
    return m_sat(pr >>> 16);
  endfunction

  function automatic logic [31:0] m_add(input logic [31:0] a, input logic [31:0] b);
    return m_sat(longint'($signed(a)) + longint'($signed(b)));
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // caller stands at a falling edge; consumes one falling edge
  task automatic hwr(input logic [1:0] s, input logic [1:0] ax, input int at, input logic [31:0] d);
    mem_we = 1'b1; mem_sel = s; mem_axis = ax; mem_atom = AW'(at); mem_wdata = d;
    @(negedge clk);
    mem_we = 1'b0;
  endtask

  task automatic hrd(input logic [1:0] s, input logic [1:0] ax, input int at, output logic [31:0] d);
    mem_sel = s; mem_axis = ax; mem_atom = AW'(at);
    #1 d = mem_rdata;
  endtask

  // drives start for one cycle; leaves cyc=1 at the first falling edge after the sampling edge
  task automatic kick(input logic ph, input int cnt, input logic [31:0] k1, input logic [31:0] k2,
                      output int cyc);
    start = 1'b1; phase = ph; atom_count = CW'(cnt); dtfm = k1; dtv = k2;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
  endtask

  task automatic wait_done(inout int cyc);
    while (!done && cyc < 2000) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  logic [31:0] rd;
  logic [31:0] fv [5][3];
  logic [31:0] vv [5][3];
  logic [31:0] pv [5][3];

  initial begin
    int cyc;
    rst_n = 1'b0; start = 1'b0; phase = 1'b0; atom_count = '0; dtfm = '0; dtv = '0;
    mem_we = 1'b0; mem_sel = '0; mem_axis = '0; mem_atom = '0; mem_wdata = '0;
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", {31'd0, busy}, 32'd0);
    chk("R1 done in reset", {31'd0, done}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 busy after reset", {31'd0, busy}, 32'd0);
    chk("R1 done after reset", {31'd0, done}, 32'd0);

    // vector table: one atom, same values on all axes (R2 R3 R4 R5)
    for (int i = 0; i < 8; i++) begin
      for (int ax = 0; ax < 3; ax++) begin
        hwr(2'd2, 2'(ax), 0, VEC[i].f);
        hwr(2'd1, 2'(ax), 0, VEC[i].v);
        hwr(2'd0, 2'(ax), 0, VEC[i].p);
      end
      kick(VEC[i].ph, 1, VEC[i].dtfm, VEC[i].dtv, cyc);
      wait_done(cyc);
      chk($sformatf("R7 done cycle vec%0d", i), cyc, 6);
      for (int ax = 0; ax < 3; ax++) begin
        hrd(2'd1, 2'(ax), 0, rd);
        chk($sformatf("R2/R3/R4/R5 vel vec%0d axis%0d", i, ax), rd, VEC[i].ev);
        hrd(2'd0, 2'(ax), 0, rd);
        chk($sformatf("R2/R3/R5 pos vec%0d axis%0d", i, ax), rd, VEC[i].ep);
      end
      @(negedge clk);
    end

    // multi-atom opening half with a host write and second start inside the run
    for (int a = 0; a < 5; a++) begin
      for (int ax = 0; ax < 3; ax++) begin
        fv[a][ax] = 32'((a*3 + ax - 5) * 74565);
        vv[a][ax] = 32'((a + ax) * 36864);
        pv[a][ax] = 32'(a*65536 - ax*1911);
        hwr(2'd2, 2'(ax), a, fv[a][ax]);
        hwr(2'd1, 2'(ax), a, vv[a][ax]);
        hwr(2'd0, 2'(ax), a, pv[a][ax]);
      end
    end
    hrd(2'd2, 2'd1, 3, rd);
    chk("R8 idle write readback", rd, fv[3][1]);
    kick(1'b0, 4, 32'h00004000, 32'h00020000, cyc);
    chk("R7 busy during run", {31'd0, busy}, 32'd1);
    hwr(2'd0, 2'd0, 4, 32'h0000DEAD);            // R8: must be ignored
    cyc++;
    start = 1'b1; phase = 1'b1; dtfm = 32'h00100000; atom_count = CW'(1);  // R9: ignored
    @(negedge clk);
    start = 1'b0;
    cyc++;
    wait_done(cyc);
    chk("R7 done cycle 4 atoms", cyc, 15);
    chk("R7 busy low with done", {31'd0, busy}, 32'd0);
    @(negedge clk);
    chk("R7 done one cycle", {31'd0, done}, 32'd0);
    for (int a = 0; a < 4; a++) begin
      for (int ax = 0; ax < 3; ax++) begin
        vv[a][ax] = m_add(vv[a][ax], m_scale(fv[a][ax], 32'h00004000));
        pv[a][ax] = m_add(pv[a][ax], m_scale(vv[a][ax], 32'h00020000));
        hrd(2'd1, 2'(ax), a, rd);
        chk($sformatf("R2/R9 vel atom%0d axis%0d", a, ax), rd, vv[a][ax]);
        hrd(2'd0, 2'(ax), a, rd);
        chk($sformatf("R2 pos atom%0d axis%0d", a, ax), rd, pv[a][ax]);
      end
    end
    hrd(2'd0, 2'd0, 4, rd);
    chk("R8 busy write ignored", rd, pv[4][0]);
    for (int ax = 0; ax < 3; ax++) begin
      hrd(2'd1, 2'(ax), 4, rd);
      chk("R6 atom beyond count vel", rd, vv[4][ax]);
      hrd(2'd0, 2'(ax), 4, rd);
      chk("R6 atom beyond count pos", rd, pv[4][ax]);
      hrd(2'd2, 2'(ax), 1, rd);
      chk("R6 force untouched", rd, fv[1][ax]);
    end

    // closing half over two atoms
    @(negedge clk);
    kick(1'b1, 2, 32'hFFFE0000, 32'h00010000, cyc);
    wait_done(cyc);
    chk("R7 done cycle 2 atoms", cyc, 9);
    for (int a = 0; a < 4; a++) begin
      for (int ax = 0; ax < 3; ax++) begin
        if (a < 2) vv[a][ax] = m_add(vv[a][ax], m_scale(fv[a][ax], 32'hFFFE0000));
        hrd(2'd1, 2'(ax), a, rd);
        chk($sformatf("R3/R6 vel atom%0d axis%0d", a, ax), rd, vv[a][ax]);
        hrd(2'd0, 2'(ax), a, rd);
        chk($sformatf("R3 pos atom%0d axis%0d", a, ax), rd, pv[a][ax]);
      end
    end

    // reset during a run
    @(negedge clk);
    kick(1'b0, 8, 32'h00010000, 32'h00010000, cyc);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 busy after abort", {31'd0, busy}, 32'd0);
    chk("R1 done after abort", {31'd0, done}, 32'd0);
    rst_n = 1'b1;
    repeat (40) @(negedge clk);
    chk("R1 no done after abort", {31'd0, done}, 32'd0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog R7 actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule